// File: doc/BRIEF.md
# Flash standby and sleep controller

This block keeps track of the power state of a parallel flash device: active, standby or automatic sleep. It watches the synchronized chip-enable, device reset, output-enable and address inputs. It also watches four status flags from the device's internal controller: read mode, algorithm busy, erase suspended and command sequence in progress. From these it drives the data-bus output enable, a low-power indication and a ready-to-read flag.

Standby follows deselection or a low device reset. A program or erase that is still running keeps the block active until the operation ends. Sleep is entered without any request once the address has stayed unchanged for an access time plus a margin, and only while the device is plainly reading. During sleep the block presents the last read word from its own holding register, so the array may change or go quiet behind it. Any change of address ends sleep at the next clock edge.

Top module: `flash_pwr_ctrl`

## Requirements
- R1: While the block reset `rst_n` is low, `pwr_state` reads standby, `low_power` is 1, and both `ready` and `bus_oe` are 0. The state codes are 0 = active, 1 = standby and 2 = sleep.
- R2: The state becomes standby at a clock edge where `rst_pin_n` is low, whether or not an algorithm is busy. It also becomes standby at a clock edge where `ce_n` is high and `algo_busy` is low. Standby takes priority over sleep. In standby `bus_oe` is 0 whatever the level of `oe_n`.
- R3: While `algo_busy` is high and `rst_pin_n` is high, the state stays active even if `ce_n` is high. The first edge after `algo_busy` falls with `ce_n` still high moves the state to standby.
- R4: Suppose the address changes and is then held. If sleep is allowed, `pwr_state` reads sleep from the (ACC_CYC+MARGIN_CYC+1)th rising edge after the change, and reads active before that. The levels of `ce_n` (while low) and `oe_n` have no effect on this timing.
- R5: Sleep is never entered while `rd_mode` is low, `algo_busy` is high, `ers_susp` is high or `cmd_seq` is high, however long the address stays stable.
- R6: During sleep, `bus_data` holds the array word present at the edge where sleep was entered, even if `array_data` changes afterwards.
- R7: The clock edge that first samples a changed address moves the state from sleep to active, and `bus_data` then follows `array_data` again. The stability count restarts, so a further full R4 interval is needed before sleep is entered again.
- R8: Outside standby, `bus_oe` equals the inverse of `oe_n`, both while active and while asleep.
- R9: After standby ends, `ready` goes to 1 at the ACC_CYC-th rising edge, counting the first edge in which the standby condition is absent. `ready` is 0 whenever the state is standby.
- R10: `low_power` is 1 exactly when the state is standby or sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low block reset |
| ce_n | input | 1 | Synchronized chip enable, active low |
| rst_pin_n | input | 1 | Synchronized device reset, active low |
| oe_n | input | 1 | Synchronized output enable, active low |
| addr | input | ADDR_W | Synchronized address bus |
| rd_mode | input | 1 | Internal controller is in plain read mode |
| algo_busy | input | 1 | Program or erase algorithm running |
| ers_susp | input | 1 | Erase is suspended |
| cmd_seq | input | 1 | A command sequence is being received |
| array_data | input | DATA_W | Word read from the array at the current address |
| bus_data | output | DATA_W | Word presented to the data bus |
| bus_oe | output | 1 | Data bus output-buffer enable |
| low_power | output | 1 | Standby or sleep indication |
| pwr_state | output | 2 | Current state code |
| ready | output | 1 | Access time since leaving standby has elapsed |

## Verification
The bench checks the sleep boundary at the exact cycle on both sides. A counter that is off by one, or that fails to restart after an address change, enters sleep one edge early or late. It also checks that a deselect while an algorithm is busy stays active, where a design that gives chip-enable alone priority would drop to standby in the middle of the operation. Each of the four sleep blockers is held over a long stable-address window, so that a missing term in the eligibility logic shows up as a spurious sleep. The array word is changed during sleep to catch a holding register that keeps loading, and the ready flag is checked one cycle before and at its expected edge.

// File: rtl/flash_pwr_pkg.sv
package flash_pwr_pkg;

    typedef enum logic [1:0] {
        PS_ACTIVE = 2'd0,
        PS_STBY   = 2'd1,
        PS_SLEEP  = 2'd2
    } pwr_state_e;

endpackage

// File: rtl/fp_addr_watch.sv
// Counts cycles of unchanged address, saturating at the sleep threshold.
module fp_addr_watch #(
    parameter int ADDR_W    = 20,
    parameter int SLEEP_CYC = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              settled_nx
);
    localparam int CW = $clog2(SLEEP_CYC + 1);
    localparam logic [CW-1:0] LIM_V = CW'(SLEEP_CYC);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CW-1:0]     cnt;
    } aw_t;

    aw_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.addr = addr;
        if (addr != st_q.addr) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != LIM_V) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        settled_nx = (st_d.cnt == LIM_V);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fp_pwr_fsm.sv
// Power state selection: standby over sleep over active.
module fp_pwr_fsm
    import flash_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       rst_pin_n,
    input  logic       algo_busy,
    input  logic       sleep_ok,
    input  logic       settled_nx,
    output pwr_state_e state_d,
    output pwr_state_e state_q
);
    logic stby_req;

    always_comb begin
        // a running algorithm keeps the part awake through a deselect,
        // but the reset pin aborts it
        stby_req = !rst_pin_n || (ce_n && !algo_busy);
        if (stby_req) begin
            state_d = PS_STBY;
        end else if (settled_nx && sleep_ok) begin
            state_d = PS_SLEEP;
        end else begin
            state_d = PS_ACTIVE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_STBY;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/fp_wake_timer.sv
// Access-time count after standby exit.
module fp_wake_timer #(
    parameter int ACC_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stby_nx,
    output logic ready
);
    localparam int WCW = $clog2(ACC_CYC + 1);
    localparam logic [WCW-1:0] ACC_V = WCW'(ACC_CYC);

    typedef struct packed {
        logic [WCW-1:0] cnt;
        logic           rdy;
    } wt_t;

    wt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stby_nx) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != ACC_V) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.rdy = (st_d.cnt == ACC_V) && !stby_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready = st_q.rdy;
endmodule

// File: rtl/fp_read_hold.sv
// Keeps the last array word on the bus while asleep.
module fp_read_hold #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              asleep,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] bus_data
);
    typedef struct packed {
        logic [DATA_W-1:0] word;
    } rh_t;

    rh_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!asleep) st_d.word = array_data;
        bus_data = asleep ? st_q.word : array_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/flash_pwr_ctrl.sv
module flash_pwr_ctrl
    import flash_pwr_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 16,
    parameter int ACC_CYC    = 4,
    parameter int MARGIN_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              rst_pin_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_mode,
    input  logic              algo_busy,
    input  logic              ers_susp,
    input  logic              cmd_seq,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_oe,
    output logic              low_power,
    output logic [1:0]        pwr_state,
    output logic              ready
);
    localparam int SLEEP_CYC = ACC_CYC + MARGIN_CYC;

    logic       settled_nx;
    logic       sleep_ok;
    pwr_state_e state_d, state_q;

    assign sleep_ok = rd_mode && !algo_busy && !ers_susp && !cmd_seq;

    fp_addr_watch #(.ADDR_W(ADDR_W), .SLEEP_CYC(SLEEP_CYC)) u_watch (
        .clk(clk), .rst_n(rst_n), .addr(addr), .settled_nx(settled_nx)
    );

    fp_pwr_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rst_pin_n(rst_pin_n),
        .algo_busy(algo_busy), .sleep_ok(sleep_ok), .settled_nx(settled_nx),
        .state_d(state_d), .state_q(state_q)
    );

    fp_wake_timer #(.ACC_CYC(ACC_CYC)) u_wake (
        .clk(clk), .rst_n(rst_n), .stby_nx(state_d == PS_STBY), .ready(ready)
    );

    fp_read_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .asleep(state_q == PS_SLEEP),
        .array_data(array_data), .bus_data(bus_data)
    );

    assign bus_oe    = !oe_n && (state_q != PS_STBY);
    assign low_power = (state_q != PS_ACTIVE);
    assign pwr_state = state_q;
endmodule

// File: rtl/fp_pwr_checker.sv
module fp_pwr_checker
    import flash_pwr_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              rst_pin_n,
    input logic              oe_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_mode,
    input logic              algo_busy,
    input logic              ers_susp,
    input logic              cmd_seq,
    input logic [DATA_W-1:0] bus_data,
    input logic              bus_oe,
    input logic              low_power,
    input logic [1:0]        pwr_state,
    input logic              ready
);
    logic [1:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age <= '0;
        else if (age != 2'd2) age <= age + 1'b1;
    end

    AST_STBY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_pin_n || (ce_n && !algo_busy)) |=> (pwr_state == PS_STBY && !bus_oe)); // R2
    AST_BUSY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (algo_busy && rst_pin_n) |=> !low_power); // R3
    AST_SLEEP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2 && pwr_state == PS_SLEEP) |->
            $past(rd_mode && !algo_busy && !ers_susp && !cmd_seq)); // R5
    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2 && pwr_state == PS_SLEEP && $past(pwr_state) == PS_SLEEP) |->
            $stable(bus_data)); // R6
    AST_ADDR_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2 && addr != $past(addr)) |=> (pwr_state != PS_SLEEP)); // R7
    AST_OE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !bus_oe); // R8
    AST_NOT_READY_STBY: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PS_STBY) |-> !ready); // R9
endmodule

bind flash_pwr_ctrl fp_pwr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rst_pin_n(rst_pin_n), .oe_n(oe_n),
    .addr(addr), .rd_mode(rd_mode), .algo_busy(algo_busy), .ers_susp(ers_susp),
    .cmd_seq(cmd_seq), .bus_data(bus_data), .bus_oe(bus_oe),
    .low_power(low_power), .pwr_state(pwr_state), .ready(ready)
);

// File: tb/sim_flash_pwr_ctrl.sv
`timescale 1ns/100ps
module sim_flash_pwr_ctrl;
    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int ACC    = 4;
    localparam int MARGIN = 3;
    localparam int LIM    = ACC + MARGIN;
    localparam logic [1:0] S_ACT = 2'd0, S_STB = 2'd1, S_SLP = 2'd2;

    logic clk = 1'b0;
    logic rst_n, ce_n, rst_pin_n, oe_n, rd_mode, algo_busy, ers_susp, cmd_seq;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] array_data, bus_data;
    logic bus_oe, low_power, ready;
    logic [1:0] pwr_state;
    int nchk = 0, nerr = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    flash_pwr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACC_CYC(ACC), .MARGIN_CYC(MARGIN)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rst_pin_n(rst_pin_n), .oe_n(oe_n),
        .addr(addr), .rd_mode(rd_mode), .algo_busy(algo_busy), .ers_susp(ers_susp),
        .cmd_seq(cmd_seq), .array_data(array_data), .bus_data(bus_data),
        .bus_oe(bus_oe), .low_power(low_power), .pwr_state(pwr_state), .ready(ready)
    );

    // {ce_n, rst_pin_n, oe_n, algo_busy, exp_state[1:0], exp_oe, exp_lp}
    localparam logic [7:0] VEC [8] = '{
        {4'b0100, S_ACT, 1'b1, 1'b0},  // R8 selected, driving
        {4'b0110, S_ACT, 1'b0, 1'b0},  // R8 output disabled
        {4'b1100, S_STB, 1'b0, 1'b1},  // R2 deselect
        {4'b0000, S_STB, 1'b0, 1'b1},  // R2 reset pin
        {4'b1101, S_ACT, 1'b1, 1'b0},  // R3 deselect while busy
        {4'b0001, S_STB, 1'b0, 1'b1},  // R2 reset pin overrides busy
        {4'b0101, S_ACT, 1'b1, 1'b0},  // R3 selected and busy
        {4'b1010, S_STB, 1'b0, 1'b1}   // R2 both
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ce_n = 1'b0; rst_pin_n = 1'b1; oe_n = 1'b0;
        rd_mode = 1'b1; algo_busy = 1'b0; ers_susp = 1'b0; cmd_seq = 1'b0;
        addr = '0; array_data = 16'h1234;
        step(); step();
        chk("R1 state", pwr_state, S_STB);
        chk("R1 low_power", low_power, 1);
        chk("R1 ready", ready, 0);
        chk("R1 bus_oe", bus_oe, 0);

        // R9: ready timing after leaving standby
        rst_n = 1'b1;
        addr = addr + 1;
        repeat (ACC - 1) step();
        chk("R9 ready early", ready, 0);
        chk("R10 active lp", low_power, 0);
        step();
        chk("R9 ready on time", ready, 1);

        // R4: sleep timing with oe_n toggling
        addr = addr + 1;
        array_data = 16'hA5A5;
        for (int i = 0; i < LIM; i++) begin
            oe_n = ~oe_n;
            step();
        end
        chk("R4 still active", pwr_state, S_ACT);
        chk("R6 bus follows array", bus_data, 16'hA5A5);
        step();
        chk("R4 asleep", pwr_state, S_SLP);
        chk("R10 sleep lp", low_power, 1);
        chk("R8 sleep oe", bus_oe, !oe_n);
        oe_n = ~oe_n;
        #1;
        chk("R8 sleep oe toggled", bus_oe, !oe_n);

        // R6: held word
        array_data = 16'h5A5A;
        step(); step();
        chk("R6 held word", bus_data, 16'hA5A5);
        chk("R6 still asleep", pwr_state, S_SLP);

        // R7: address change wakes, count restarts
        addr = addr + 1;
        step();
        chk("R7 wake", pwr_state, S_ACT);
        chk("R7 bus follows", bus_data, 16'h5A5A);
        repeat (LIM - 1) step();
        chk("R7 restart not early", pwr_state, S_ACT);
        step();
        chk("R7 resleep", pwr_state, S_SLP);

        // R5: each blocker
        for (int b = 0; b < 4; b++) begin
            rd_mode = (b != 0); ers_susp = (b == 1); cmd_seq = (b == 2); algo_busy = (b == 3);
            addr = addr + 1;
            repeat (LIM + 3) step();
            chk($sformatf("R5 blocker %0d", b), pwr_state, S_ACT);
        end
        rd_mode = 1'b1; ers_susp = 1'b0; cmd_seq = 1'b0; algo_busy = 1'b0;
        step();
        chk("R5 sleep after unblock", pwr_state, S_SLP);

        // R2: deselect during sleep wins
        ce_n = 1'b1;
        step();
        chk("R2 standby over sleep", pwr_state, S_STB);
        chk("R9 ready dropped", ready, 0);

        // R3: busy release while deselected
        ce_n = 1'b0; addr = addr + 1;
        step();
        algo_busy = 1'b1; ce_n = 1'b1;
        step(); step();
        chk("R3 busy holds active", pwr_state, S_ACT);
        algo_busy = 1'b0;
        step();
        chk("R3 standby after busy", pwr_state, S_STB);

        // table of port-level state vectors
        for (int i = 0; i < 8; i++) begin
            {ce_n, rst_pin_n, oe_n, algo_busy} = VEC[i][7:4];
            addr = addr + 1;
            step();
            chk($sformatf("R2/R3 vec %0d state", i), pwr_state, VEC[i][3:2]);
            chk($sformatf("R8 vec %0d bus_oe", i), bus_oe, VEC[i][1]);
            chk($sformatf("R10 vec %0d lp", i), low_power, VEC[i][0]);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule